// File: doc/BRIEF.md
# SD card clock prescaler and divider

This block turns a fast host clock into the SD card clock. Software-facing logic elsewhere presents the host clock rate, the wanted card clock rate and a double-data-rate flag, then pulses `start`. The block picks a power-of-two prescaler and a linear divisor, one search step per cycle. It writes both as encoded fields into a control word together with a clock-enable bit. It also reports the card clock rate the chosen setting gives.

The search is greedy and has two stages. First the prescaler doubles from 1 while the host rate still exceeds sixteen times the target scaled by the current prescale. Then the divisor counts up from 1 while the host rate still exceeds the target scaled by the whole ratio. In double-data-rate mode a fixed extra divide by two multiplies into every product. No division is used for the comparisons. The reported rate comes from a short serial division once the search has ended.

While a new setting is being worked out, the enable bit and the old fields are held clear and the card clock is held low. After `done`, a counter clocked at the host rate toggles `sdClk` with the selected total ratio.

Top module: `sdclk_divider`

## Requirements
- R1: A `start` pulse while idle latches `hostFreq`, `targetFreq` and `ddrMode`. `busy` is high from the next cycle through the `done` cycle. A `start` while busy is ignored, and the result follows the first request's inputs.
- R2: The prescaler P is a power of two from 1 to 256. It starts at 1 and doubles while hostFreq > target × 16 × P × X and P < 256, where X is the mode factor. It is encoded in `clkCtrl[7:0]` as P/2, so P = 1 gives 0 and P = 256 gives 0x80.
- R3: The divisor D starts at 1 and increments while hostFreq > target × D × P × X and D < 16. It is encoded in `clkCtrl[11:8]` as D − 1.
- R4: X is 2 when `ddrMode` is 1 and 1 when it is 0, so the total prescale reaches 512 in double-data-rate mode.
- R5: At `done`, `actualFreq` equals floor(hostFreq / (D × P × X)).
- R6: From the cycle after an accepted `start` until `done`, `clkCtrl[12]` (clock enable) is 0, the field bits are cleared, and `sdClk` is low.
- R7: `done` is a one-cycle pulse. In that cycle `clkCtrl[12]` is already 1 and the fields hold the new setting.
- R8: With N = D × P × X, `sdClk` goes high one cycle after `done`. It then repeats with period N host cycles: high for ceil(N/2) cycles and low for floor(N/2). For N = 1 it stays high.
- R9: A target of 0 still ends with a `done` pulse, but `clkCtrl` is all zero, `actualFreq` is 0 and `sdClk` stays low.
- R10: The comparisons are exact over the full input range, with no overflow, including hostFreq and target both at 2^32 − 1 in double-data-rate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new setting (taken only when idle) |
| ddrMode | input | 1 | 1 selects double-data-rate (extra divide by two) |
| hostFreq | input | 32 | Host clock rate, any unit |
| targetFreq | input | 32 | Wanted card clock rate, same unit |
| busy | output | 1 | Search or apply in progress |
| done | output | 1 | One-cycle completion pulse |
| clkCtrl | output | 13 | [7:0] prescaler code, [11:8] divisor code, [12] clock enable |
| actualFreq | output | 32 | Achieved card clock rate |
| sdClk | output | 1 | Divided card clock |

## Verification
The bench targets the ends of both search ranges:
- Equal host and target rates give a prescaler of 1. A design that kept the old minimum of 2 would report code 1 instead of 0.
- A huge host rate with a target of 1 must saturate at 256 and 16. A design that counted one step too far would wrap the fields.
- Targets at the top of the 32-bit range, in double-data-rate mode, expose a product register that is too narrow: the comparison would wrap and pick a large divider.

It also checks four behaviours:
- Odd ratios have the longer high phase, and a ratio of 1 holds the clock high.
- A zero target must leave the clock gated.
- A start during a search must not disturb the result.
- During the search the card clock must stay low. A design that cleared the enable one cycle late would leak a stray pulse.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int PRE_FIELD_W = 8;
  localparam int DIV_FIELD_W = 4;
  localparam int PRE_MAX_LOG = 8;
  localparam int DIV_MAX     = 16;
  localparam int CTRL_EN_BIT = PRE_FIELD_W + DIV_FIELD_W;
  localparam int CTRL_W      = CTRL_EN_BIT + 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_DIV,
    S_QUO,
    S_APPLY,
    S_FIN
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic preStep;
    logic divInit;
    logic divStep;
    logic quoInit;
    logic quoStep;
    logic apply;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic tgtZero;
    logic preMore;
    logic divMore;
    logic quoLast;
  } dpStat_t;

endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    busy,
  output logic    done
);

  state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          cmd.load  = 1'b1;
          stateNext = S_PRE;
        end
      end
      S_PRE: begin
        if (stat.tgtZero) begin
          stateNext = S_FIN;
        end else if (stat.preMore) begin
          cmd.preStep = 1'b1;
        end else begin
          cmd.divInit = 1'b1;
          stateNext   = S_DIV;
        end
      end
      S_DIV: begin
        if (stat.divMore) begin
          cmd.divStep = 1'b1;
        end else begin
          cmd.quoInit = 1'b1;
          stateNext   = S_QUO;
        end
      end
      S_QUO: begin
        cmd.quoStep = 1'b1;
        if (stat.quoLast) stateNext = S_APPLY;
      end
      S_APPLY: begin
        cmd.apply = 1'b1;
        stateNext = S_FIN;
      end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  // R1: once busy, stays busy until the done cycle
  a_r1_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R7: done lasts exactly one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: a start while busy does not re-load the datapath
  a_r1_no_reload_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmd.load);

endmodule

// File: rtl/sdclk_datapath.sv
module sdclk_datapath
  import sdclk_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              ddrIn,
  input  logic [FREQ_W-1:0] hostIn,
  input  logic [FREQ_W-1:0] tgtIn,
  output dpStat_t           stat,
  output logic [CTRL_W-1:0] clkCtrl,
  output logic [FREQ_W-1:0] actualFreq,
  output logic              sdClk
);

  localparam int DIV_LOG = $clog2(DIV_MAX);
  localparam int PROD_W  = FREQ_W + PRE_MAX_LOG + DIV_LOG + 1;
  localparam int LOG_W   = $clog2(PRE_MAX_LOG + DIV_LOG + 2);
  localparam int DIV_W   = DIV_LOG + 1;
  localparam int TOT_W   = PRE_MAX_LOG + DIV_LOG + 2;
  localparam int QCNT_W  = $clog2(FREQ_W);
  localparam int REM_W   = DIV_W;

  logic [FREQ_W-1:0] hostQ, tgtQ;
  logic              ddrQ;
  logic [LOG_W-1:0]  preLog;
  logic [DIV_W-1:0]  divCnt;
  logic [PROD_W-1:0] stepQ, prodQ;
  logic [FREQ_W-1:0] dvdQ;
  logic [REM_W-1:0]  remQ;
  logic [QCNT_W-1:0] quoCnt;
  logic [TOT_W-1:0]  totalDiv, phaseCnt;

  // search arithmetic, no division
  logic [LOG_W-1:0]  preShift;
  logic [PROD_W-1:0] hostExt, preProd;
  assign preShift = preLog + LOG_W'(ddrQ);
  assign hostExt  = PROD_W'(hostQ);
  assign preProd  = PROD_W'(tgtQ) << (preShift + LOG_W'(DIV_LOG));

  assign stat.tgtZero = (tgtQ == '0);
  assign stat.preMore = (hostExt > preProd) && (preLog < LOG_W'(PRE_MAX_LOG));
  assign stat.divMore = (hostExt > prodQ) && (divCnt < DIV_W'(DIV_MAX));
  assign stat.quoLast = (quoCnt == QCNT_W'(FREQ_W - 1));

  // field encodings
  logic [PRE_FIELD_W:0]   preOneHot;
  logic [PRE_FIELD_W-1:0] preCode;
  logic [DIV_FIELD_W-1:0] divCode;
  assign preOneHot = (PRE_FIELD_W + 1)'(1) << preLog;
  assign preCode   = preOneHot[PRE_FIELD_W:1];
  assign divCode   = DIV_FIELD_W'(divCnt - DIV_W'(1));

  // restoring division step
  logic [REM_W:0] remSh;
  logic           fits;
  assign remSh = {remQ, dvdQ[FREQ_W-1]};
  assign fits  = (remSh >= {1'b0, divCnt});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostQ  <= '0;
      tgtQ   <= '0;
      ddrQ   <= 1'b0;
      preLog <= '0;
      divCnt <= DIV_W'(1);
      stepQ  <= '0;
      prodQ  <= '0;
      dvdQ   <= '0;
      remQ   <= '0;
      quoCnt <= '0;
    end else begin
      if (cmd.load) begin
        hostQ  <= hostIn;
        tgtQ   <= tgtIn;
        ddrQ   <= ddrIn;
        preLog <= '0;
        divCnt <= DIV_W'(1);
      end
      if (cmd.preStep) preLog <= preLog + LOG_W'(1);
      if (cmd.divInit) begin
        stepQ  <= PROD_W'(tgtQ) << preShift;
        prodQ  <= PROD_W'(tgtQ) << preShift;
        divCnt <= DIV_W'(1);
      end
      if (cmd.divStep) begin
        divCnt <= divCnt + DIV_W'(1);
        prodQ  <= prodQ + stepQ;
      end
      if (cmd.quoInit) begin
        dvdQ   <= hostQ >> preShift;
        remQ   <= '0;
        quoCnt <= '0;
      end
      if (cmd.quoStep) begin
        remQ   <= fits ? REM_W'(remSh - {1'b0, divCnt}) : REM_W'(remSh);
        dvdQ   <= {dvdQ[FREQ_W-2:0], fits};
        quoCnt <= quoCnt + QCNT_W'(1);
      end
    end
  end

  // control word and reported rate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCtrl    <= '0;
      actualFreq <= '0;
      totalDiv   <= TOT_W'(1);
    end else if (cmd.load) begin
      clkCtrl    <= '0;
      actualFreq <= '0;
    end else if (cmd.apply) begin
      clkCtrl    <= {1'b1, divCode, preCode};
      actualFreq <= dvdQ;
      totalDiv   <= TOT_W'(divCnt) << preShift;
    end
  end

  // divided clock
  logic [TOT_W:0]   totPlus;
  logic [TOT_W-1:0] highLen;
  logic             clkOn;
  assign totPlus = {1'b0, totalDiv} + (TOT_W + 1)'(1);
  assign highLen = totPlus[TOT_W:1];
  assign clkOn   = clkCtrl[CTRL_EN_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      sdClk    <= 1'b0;
    end else if (!clkOn || cmd.load) begin
      phaseCnt <= '0;
      sdClk    <= 1'b0;
    end else begin
      sdClk    <= (phaseCnt < highLen);
      phaseCnt <= (phaseCnt == totalDiv - TOT_W'(1)) ? '0 : phaseCnt + TOT_W'(1);
    end
  end

  // R7: applying a setting turns the enable on
  a_r7_apply_enables: assert property (@(posedge clk) disable iff (!rstN)
    cmd.apply |=> clkCtrl[CTRL_EN_BIT]);

  // R2: prescaler code is zero or a single set bit
  a_r2_pre_code_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clkCtrl[PRE_FIELD_W-1:0]));

  // R3: divisor stays within 1..16
  a_r3_div_range: assert property (@(posedge clk) disable iff (!rstN)
    (divCnt >= DIV_W'(1)) && (divCnt <= DIV_W'(DIV_MAX)));

  // R10: the running product never wraps
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cmd.divStep |=> (prodQ > $past(prodQ)));

  // R8: with the enable off, the card clock falls low
  a_r8_off_means_low: assert property (@(posedge clk) disable iff (!rstN)
    !clkOn |=> !sdClk);

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              ddrMode,
  input  logic [FREQ_W-1:0] hostFreq,
  input  logic [FREQ_W-1:0] targetFreq,
  output logic              busy,
  output logic              done,
  output logic [CTRL_W-1:0] clkCtrl,
  output logic [FREQ_W-1:0] actualFreq,
  output logic              sdClk
);

  dpCmd_t  cmd;
  dpStat_t stat;

  sdclk_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .cmd   (cmd),
    .busy  (busy),
    .done  (done)
  );

  sdclk_datapath #(.FREQ_W(FREQ_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .ddrIn      (ddrMode),
    .hostIn     (hostFreq),
    .tgtIn      (targetFreq),
    .stat       (stat),
    .clkCtrl    (clkCtrl),
    .actualFreq (actualFreq),
    .sdClk      (sdClk)
  );

  // R6: nothing leaks out while a new setting is being worked out
  a_r6_gated_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |-> (!sdClk && !clkCtrl[CTRL_EN_BIT] && (clkCtrl == '0)));

endmodule

// File: tb/sdclk_divider_test.sv
`timescale 1ns/1ps
module sdclk_divider_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        ddrMode = 1'b0;
  logic [31:0] hostFreq = '0;
  logic [31:0] targetFreq = '0;
  logic        busy, done, sdClk;
  logic [12:0] clkCtrl;
  logic [31:0] actualFreq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sdclk_divider uut (
    .clk(clk), .rstN(rstN), .start(start), .ddrMode(ddrMode),
    .hostFreq(hostFreq), .targetFreq(targetFreq), .busy(busy), .done(done),
    .clkCtrl(clkCtrl), .actualFreq(actualFreq), .sdClk(sdClk)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected search result from the requirements
  task automatic model(input longint h, input longint t, input bit ddr,
                       output longint pre, output longint dv, output longint act);
    longint x;
    x = ddr ? 2 : 1;
    pre = 1;
    while (h > t * 16 * pre * x && pre < 256) pre = pre * 2;
    dv = 1;
    while (h > t * dv * pre * x && dv < 16) dv = dv + 1;
    act = h / (dv * pre * x);
  endtask

  task automatic runCase(input longint h, input longint t, input bit ddr, input bit poke);
    longint pre, dv, act, n, hi, lo;
    bit gateOk, sawDone, stayOk;
    model(h, t, ddr, pre, dv, act);
    @(negedge clk);
    hostFreq = h[31:0]; targetFreq = t[31:0]; ddrMode = ddr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    gateOk = 1'b1; sawDone = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin sawDone = 1'b1; break; end
      if (sdClk || clkCtrl != 13'd0) gateOk = 1'b0;
      start = (poke && i == 2);
      if (poke && i == 2) begin
        targetFreq = targetFreq + 32'd7;
        ddrMode = ~ddrMode;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(sawDone, "R7 done pulse seen", sawDone, 1);
    check(gateOk, "R6 gated while busy", gateOk, 1);
    if (t == 0) begin
      check(clkCtrl == 13'd0, "R9 zero target control word", clkCtrl, 0);
      check(actualFreq == 32'd0, "R9 zero target rate", actualFreq, 0);
      stayOk = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sdClk) stayOk = 1'b0;
      end
      check(stayOk, "R9 clock stays low", sdClk, 0);
      return;
    end
    check(clkCtrl[12] == 1'b1, "R7 enable set at done", clkCtrl[12], 1);
    check(clkCtrl[7:0] == 8'(pre >> 1), poke ? "R1 prescaler of first request" :
          (ddr ? "R4 prescaler code" : "R2 prescaler code"), clkCtrl[7:0], pre >> 1);
    check(clkCtrl[11:8] == 4'(dv - 1), "R3 divisor code", clkCtrl[11:8], dv - 1);
    check(actualFreq == 32'(act), (h > 64'h7fff_ffff) ? "R10 achieved rate" : "R5 achieved rate",
          actualFreq, act);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", done, 0);
    n = dv * pre * (ddr ? 2 : 1);
    check(sdClk == 1'b1, "R8 first high one cycle after done", sdClk, 1);
    if (n == 1) begin
      stayOk = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!sdClk) stayOk = 1'b0;
      end
      check(stayOk, "R8 ratio one holds high", sdClk, 1);
    end else if (n <= 512) begin
      hi = 0; lo = 0;
      while (sdClk && hi <= n) begin hi++; @(negedge clk); end
      while (!sdClk && lo <= n) begin lo++; @(negedge clk); end
      check(hi == (n + 1) / 2, "R8 high phase", hi, (n + 1) / 2);
      check(lo == n / 2, "R8 low phase", lo, n / 2);
    end
  endtask

  initial begin
    longint h, t;
    void'($urandom(32'd20250117));
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset idle", busy, 0);
    check(clkCtrl == 13'd0, "R6 reset control word", clkCtrl, 0);
    check(sdClk == 1'b0, "R8 reset clock low", sdClk, 0);
    rstN = 1'b1;
    @(negedge clk);

    runCase(100, 100, 1'b0, 1'b0);                 // R2 divide by one in SDR
    runCase(100, 100, 1'b1, 1'b0);                 // R4 DDR ratio 2
    runCase(200000000, 400000, 1'b0, 1'b0);        // R2 R3 mid range
    runCase(48000000, 5000000, 1'b1, 1'b0);        // R4 odd divisor
    runCase(35, 5, 1'b0, 1'b0);                    // R8 odd ratio 7
    runCase(64'hffff_ffff, 1, 1'b1, 1'b0);         // R10 saturation 256/16
    runCase(64'hffff_ffff, 64'hffff_ffff, 1'b1, 1'b0); // R10 wide product
    runCase(1000, 0, 1'b0, 1'b0);                  // R9 zero target
    runCase(3000000, 100000, 1'b0, 1'b1);          // R1 start while busy

    for (int r = 0; r < 30; r++) begin
      h = 1000000 + longint'($urandom_range(0, 199000000));
      t = h / longint'($urandom_range(1, 300)) + longint'($urandom_range(0, 1000));
      runCase(h, t, 1'($urandom_range(0, 1)), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule